// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block is the system-side master for a serially controlled analog-to-digital converter that returns each conversion one transfer late. A client presents a channel number and a transfer-length code together with a one-cycle `start` pulse while `ready` is high. The block lowers the chip select and produces a divided serial clock. It shifts an 8-bit control word out MSB first. On the same clock edges it gathers the bits the converter sends back. After the last falling serial clock edge it raises the chip select and waits for the converter's end-of-conversion line to go low and then high again. Only after that does it accept another request.

Each burst carries exactly the number of serial clocks the request selects, so the converter stays in step even when that cuts short the previous result. The bits gathered in a burst are the result of the request made in the burst before. The block therefore keeps a one-entry tag holding the previous channel and reports each result with that tag. The very first burst after reset returns nothing usable, and it produces no result strobe. A programmable watchdog limits the wait for end-of-conversion. If the limit runs out, the block flags an error and returns to idle.

The controller has six states. `ST_IDLE` accepts a request and moves to `ST_LEAD`. `ST_LEAD` holds the chip select low and the serial clock low for one half-period, then moves to `ST_CLK_HI`. `ST_CLK_HI` drives the clock high for one half-period, then moves to `ST_CLK_LO`. `ST_CLK_LO` drives the clock low for one half-period. It goes back to `ST_CLK_HI` while bits remain, and otherwise ends the burst into `ST_CONV_LO`. `ST_CONV_LO` waits for end-of-conversion to read low and then moves to `ST_CONV_HI`. `ST_CONV_HI` waits for it to read high and then moves to `ST_IDLE`. From either conversion state, watchdog expiry also leads to `ST_IDLE`.

Top module: `adc_serial_host`

## Requirements
- R1: After reset `adc_cs_n` is 1, `adc_clk` is 0, `ready` is 1, and `res_valid` and `timeout_err` are 0.
- R2: A burst has exactly 8, 12 or 16 rising `adc_clk` edges for `req_len` codes 0, 1 and 2. Code 3 also gives 16.
- R3: The control word goes out MSB first on `adc_din`. Bits 7:4 hold the channel, bits 3:2 the length code, and bits 1:0 are zero. `adc_din` changes only when `adc_clk` falls, or before the first rising edge.
- R4: Each high phase and each low phase of `adc_clk` lasts `half_cycles` system clocks, with the value taken when the request is accepted. `adc_cs_n` is low for exactly one half-period before the first rising edge, and `adc_clk` toggles only while `adc_cs_n` is low.
- R5: `adc_dout` is sampled at each rising `adc_clk` edge. The N bits form `res_data` right-justified, and the first bit received is the most significant.
- R6: `res_valid` is a single-cycle pulse. It coincides with the rise of `adc_cs_n` at the end of a burst, and `res_chan` then carries the channel of the previous accepted request.
- R7: The first burst after reset produces no `res_valid` pulse.
- R8: Between bursts `adc_cs_n` stays high. A new burst cannot begin until `adc_eoc` has been seen low and then high after the previous burst, and `ready` is high only in idle.
- R9: If `adc_eoc` does not return high within `timeout_lim` system clocks after the end of a burst, `timeout_err` rises `timeout_lim`+1 clocks after `adc_cs_n` rose, and the block returns to idle. The flag clears when the next request is accepted.
- R10: A `start` pulse while `ready` is low is ignored: the burst in progress and the next burst's control word and result tag are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken only while `ready` is high |
| req_chan | input | 4 | Channel for the request |
| req_len | input | 2 | Length code: 0 = 8, 1 = 12, 2 or 3 = 16 clocks |
| half_cycles | input | DIV_W | System clocks per serial clock half-period (0 acts as 1) |
| timeout_lim | input | TO_W | Watchdog limit in system clocks |
| ready | output | 1 | Idle and able to accept a request |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_clk | output | 1 | Serial I/O clock to the converter |
| adc_din | output | 1 | Control word bit to the converter |
| adc_dout | input | 1 | Result bit from the converter |
| adc_eoc | input | 1 | Converter end-of-conversion, asynchronous |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Received result, right-justified |
| res_chan | output | 4 | Channel the result belongs to |
| timeout_err | output | 1 | Watchdog expiry flag |

## Verification
The assertions take three things for granted. `start` arrives only as a clean one-cycle pulse, `half_cycles` stays fixed while a burst runs, and the converter pulls end-of-conversion low soon after the burst ends. If end-of-conversion never goes low, only the watchdog releases the controller. The bench changes `half_cycles` and `timeout_lim` only while the block is idle. Its converter model lowers end-of-conversion a fixed short time after the chip select rises and raises it again after a conversion delay much shorter than the normal limit. The one exception is the watchdog scenario, where it deliberately leaves the line low.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;

    localparam int CHAN_W     = 4;
    localparam int LEN_CODE_W = 2;
    localparam int CTRL_W     = 8;
    localparam int RES_W      = 16;
    localparam int BIT_CNT_W  = $clog2(RES_W + 1);
    localparam int CTRL_PAD_W = CTRL_W - CHAN_W - LEN_CODE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_CLK_HI,
        ST_CLK_LO,
        ST_CONV_LO,
        ST_CONV_HI
    } host_state_e;

    // Number of serial clocks a length code asks for.
    function automatic logic [BIT_CNT_W-1:0] burst_bits(input logic [LEN_CODE_W-1:0] code);
        logic [BIT_CNT_W-1:0] n;
        case (code)
            2'd0:    n = BIT_CNT_W'(8);
            2'd1:    n = BIT_CNT_W'(12);
            default: n = BIT_CNT_W'(16);
        endcase
        return n;
    endfunction

    // Control word: channel in the top nibble, length code below it, padding zeros.
    function automatic logic [CTRL_W-1:0] make_ctrl(input logic [CHAN_W-1:0] chan,
                                                    input logic [LEN_CODE_W-1:0] code);
        return {chan, code, {CTRL_PAD_W{1'b0}}};
    endfunction

endpackage

// File: rtl/adc_host_sync.sv
`timescale 1ns/1ps
module adc_host_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_host_shifter.sv
`timescale 1ns/1ps
module adc_host_shifter #(
    parameter int TX_W = 8,
    parameter int RX_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_word,
    input  logic            tx_shift,
    input  logic            rx_sample,
    input  logic            rx_bit,
    output logic            tx_msb,
    output logic [RX_W-1:0] rx_word
);
    logic [TX_W-1:0] tx_q;
    logic [RX_W-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (load) begin
            tx_q <= load_word;
            rx_q <= '0;
        end else begin
            if (tx_shift) begin
                tx_q <= {tx_q[TX_W-2:0], 1'b0};
            end
            if (rx_sample) begin
                rx_q <= {rx_q[RX_W-2:0], rx_bit};
            end
        end
    end

    assign tx_msb  = tx_q[TX_W-1];
    assign rx_word = rx_q;
endmodule

// File: rtl/adc_host_wdog.sv
`timescale 1ns/1ps
module adc_host_wdog #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (cnt_q >= limit);
endmodule

// File: rtl/adc_serial_host.sv
`timescale 1ns/1ps
module adc_serial_host
    import adc_host_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int TO_W        = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic [1:0]        req_len,
    input  logic [DIV_W-1:0]  half_cycles,
    input  logic [TO_W-1:0]   timeout_lim,
    output logic              ready,
    output logic              adc_cs_n,
    output logic              adc_clk,
    output logic              adc_din,
    input  logic              adc_dout,
    input  logic              adc_eoc,
    output logic              res_valid,
    output logic [RES_W-1:0]  res_data,
    output logic [CHAN_W-1:0] res_chan,
    output logic              timeout_err
);
    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);

    host_state_e state_q, state_d;

    logic [DIV_W-1:0]     div_cnt, half_q, half_eff;
    logic [BIT_CNT_W-1:0] bit_cnt, len_q;
    logic [CHAN_W-1:0]    chan_q, tag_q;
    logic                 have_prev, err_q;
    logic                 eoc_s, div_done, accept;
    logic                 enter_hi, enter_lo, burst_end;
    logic                 wd_run, wd_expired, timed_out;
    logic                 tx_msb;
    logic [RES_W-1:0]     rx_word;
    logic                 cs_n_q, sclk_q, res_valid_q;
    logic [RES_W-1:0]     res_data_q;
    logic [CHAN_W-1:0]    res_chan_q;

    adc_host_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_eoc_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (adc_eoc),
        .q     (eoc_s)
    );

    adc_host_shifter #(
        .TX_W (CTRL_W),
        .RX_W (RES_W)
    ) u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word (make_ctrl(req_chan, req_len)),
        .tx_shift  (enter_lo),
        .rx_sample (enter_hi),
        .rx_bit    (adc_dout),
        .tx_msb    (tx_msb),
        .rx_word   (rx_word)
    );

    adc_host_wdog #(
        .CNT_W (TO_W)
    ) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wd_run),
        .limit   (timeout_lim),
        .expired (wd_expired)
    );

    // Decoded events.
    assign half_eff  = (half_cycles == '0) ? DIV_ONE : half_cycles;
    assign div_done  = (div_cnt == half_q - DIV_ONE);
    assign accept    = (state_q == ST_IDLE) && start;
    assign enter_hi  = (state_q != ST_CLK_HI) && (state_d == ST_CLK_HI);
    assign enter_lo  = (state_q == ST_CLK_HI) && (state_d == ST_CLK_LO);
    assign burst_end = (state_q == ST_CLK_LO) && (state_d == ST_CONV_LO);
    assign wd_run    = (state_q == ST_CONV_LO) || (state_q == ST_CONV_HI);
    assign timed_out = wd_run && wd_expired && !((state_q == ST_CONV_HI) && eoc_s);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_LEAD;
            end
            ST_LEAD: begin
                if (div_done) state_d = ST_CLK_HI;
            end
            ST_CLK_HI: begin
                if (div_done) state_d = ST_CLK_LO;
            end
            ST_CLK_LO: begin
                if (div_done) state_d = (bit_cnt == len_q) ? ST_CONV_LO : ST_CLK_HI;
            end
            ST_CONV_LO: begin
                if (wd_expired)  state_d = ST_IDLE;
                else if (!eoc_s) state_d = ST_CONV_HI;
            end
            ST_CONV_HI: begin
                if (eoc_s)           state_d = ST_IDLE;
                else if (wd_expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Divider, bit counter, request and tag registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt   <= '0;
            half_q    <= DIV_ONE;
            bit_cnt   <= '0;
            len_q     <= burst_bits(2'd0);
            chan_q    <= '0;
            tag_q     <= '0;
            have_prev <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            if ((state_q == ST_IDLE) || (state_d != state_q)) begin
                div_cnt <= '0;
            end else begin
                div_cnt <= div_cnt + DIV_ONE;
            end
            if (accept) begin
                half_q  <= half_eff;
                len_q   <= burst_bits(req_len);
                chan_q  <= req_chan;
                bit_cnt <= '0;
                err_q   <= 1'b0;
            end
            if (enter_hi) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (burst_end) begin
                tag_q     <= chan_q;
                have_prev <= 1'b1;
            end
            if (timed_out) begin
                err_q <= 1'b1;
            end
        end
    end

    // Registered outputs, decoded from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q      <= 1'b1;
            sclk_q      <= 1'b0;
            res_valid_q <= 1'b0;
            res_data_q  <= '0;
            res_chan_q  <= '0;
        end else begin
            cs_n_q      <= !((state_d == ST_LEAD) || (state_d == ST_CLK_HI) ||
                             (state_d == ST_CLK_LO));
            sclk_q      <= (state_d == ST_CLK_HI);
            res_valid_q <= burst_end && have_prev;
            if (burst_end) begin
                res_data_q <= rx_word;
                res_chan_q <= tag_q;
            end
        end
    end

    assign ready       = (state_q == ST_IDLE);
    assign adc_cs_n    = cs_n_q;
    assign adc_clk     = sclk_q;
    assign adc_din     = tx_msb;
    assign res_valid   = res_valid_q;
    assign res_data    = res_data_q;
    assign res_chan    = res_chan_q;
    assign timeout_err = err_q;
endmodule

// File: rtl/adc_serial_host_chk.sv
`timescale 1ns/1ps
module adc_serial_host_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic ready,
    input logic adc_cs_n,
    input logic adc_clk,
    input logic adc_din,
    input logic res_valid,
    input logic timeout_err
);
    assert_clk_needs_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_clk |-> !adc_cs_n);

    assert_clk_low_at_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> !adc_clk);

    assert_din_steady_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_clk && $past(adc_clk)) |-> $stable(adc_din));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    assert_valid_at_burst_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $rose(adc_cs_n));

    assert_idle_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> adc_cs_n);

    assert_burst_from_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> ($past(ready) && $past(start)));

    assert_err_returns_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> ready);
endmodule

bind adc_serial_host adc_serial_host_chk u_chk (.*);

// File: tb/adc_serial_host_bench.sv
`timescale 1ns/1ps
module adc_serial_host_bench;
    localparam int CLK_NS  = 20;
    localparam int CONV_NS = 800;
    localparam int TO_LIM  = 50;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [3:0]  req_chan;
    logic [1:0]  req_len;
    logic [7:0]  half_cycles;
    logic [15:0] timeout_lim;
    logic        ready, adc_cs_n, adc_clk, adc_din;
    logic        adc_dout, adc_eoc;
    logic        res_valid;
    logic [15:0] res_data;
    logic [3:0]  res_chan;
    logic        timeout_err;

    adc_serial_host u_adc_serial_host (
        .clk(clk), .rst_n(rst_n), .start(start), .req_chan(req_chan),
        .req_len(req_len), .half_cycles(half_cycles), .timeout_lim(timeout_lim),
        .ready(ready), .adc_cs_n(adc_cs_n), .adc_clk(adc_clk), .adc_din(adc_din),
        .adc_dout(adc_dout), .adc_eoc(adc_eoc), .res_valid(res_valid),
        .res_data(res_data), .res_chan(res_chan), .timeout_err(timeout_err)
    );

    always #(CLK_NS/2) clk = ~clk;

    int compared   = 0;
    int mismatched = 0;
    int ch_arr[0:15];
    int len_arr[0:15];
    int cur_idx    = -1;
    int cur_half   = 2;
    int valid_seen = 0;
    int err_seen   = 0;
    int bitn       = 0;
    bit hang       = 1'b0;
    bit armed      = 1'b0;
    bit converting = 1'b0;
    bit first_edge = 1'b0;
    bit prev_valid = 1'b0;
    logic [7:0]  ctl;
    logic [15:0] shreg;
    logic [15:0] adc_result;
    time t_cs_fall, t_last_fall, t_last_rise, t_cs_rise;

    function automatic int exp_bits(input int code);
        return (code == 0) ? 8 : ((code == 1) ? 12 : 16);
    endfunction

    function automatic logic [15:0] conv_val(input logic [3:0] c);
        return {c, c ^ 4'hA, ~c, 4'h3};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Behavioural converter model.
    always @(negedge adc_cs_n) begin
        if (adc_cs_n === 1'b0) begin
            check(!converting, "R8", "select during conversion", longint'(converting), 0);
            armed      = 1'b1;
            bitn       = 0;
            ctl        = 8'h00;
            shreg      = adc_result;
            adc_dout   = shreg[15];
            t_cs_fall  = $time;
            first_edge = 1'b1;
        end
    end

    always @(posedge adc_clk) begin
        if (armed) begin
            if (first_edge)
                check(($time - t_cs_fall) == longint'(cur_half * CLK_NS), "R4", "select lead",
                      longint'($time - t_cs_fall), longint'(cur_half * CLK_NS));
            else
                check(($time - t_last_fall) == longint'(cur_half * CLK_NS), "R4", "low phase",
                      longint'($time - t_last_fall), longint'(cur_half * CLK_NS));
            first_edge  = 1'b0;
            t_last_rise = $time;
            if (bitn < 8) ctl = {ctl[6:0], adc_din};
            bitn++;
        end
    end

    always @(negedge adc_clk) begin
        if (armed && adc_cs_n === 1'b0) begin
            check(($time - t_last_rise) == longint'(cur_half * CLK_NS), "R4", "high phase",
                  longint'($time - t_last_rise), longint'(cur_half * CLK_NS));
            t_last_fall = $time;
            shreg       = shreg << 1;
            adc_dout    = shreg[15];
        end
    end

    always @(posedge adc_cs_n) begin
        if (armed) begin
            armed     = 1'b0;
            t_cs_rise = $time;
            check(bitn == exp_bits(len_arr[cur_idx]), "R2", "clock count",
                  bitn, exp_bits(len_arr[cur_idx]));
            check(int'(ctl[7:4]) == ch_arr[cur_idx], "R3", "control channel",
                  ctl[7:4], ch_arr[cur_idx]);
            check(int'(ctl[3:2]) == len_arr[cur_idx], "R3", "control length",
                  ctl[3:2], len_arr[cur_idx]);
            check(ctl[1:0] == 2'b00, "R3", "control pad", ctl[1:0], 0);
            adc_result = conv_val(ctl[7:4]);
            converting = 1'b1;
            #30;
            adc_eoc = 1'b0;
            if (!hang) begin
                #(CONV_NS);
                adc_eoc    = 1'b1;
                converting = 1'b0;
            end
        end
    end

    always @(posedge timeout_err) begin
        if (rst_n === 1'b1) begin
            err_seen++;
            check(($time - t_cs_rise) == longint'((TO_LIM + 1) * CLK_NS), "R9", "timeout delay",
                  longint'($time - t_cs_rise), longint'((TO_LIM + 1) * CLK_NS));
        end
    end

    // Reference comparison on every clock.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            check(!(adc_clk && adc_cs_n), "R4", "clock while deselected", adc_clk, 0);
            check(!(ready && !adc_cs_n), "R8", "idle while selected", adc_cs_n, 1);
            check(!(res_valid && prev_valid), "R6", "strobe width", 2, 1);
            if (res_valid) begin
                valid_seen++;
                check(cur_idx >= 1, "R7", "strobe on first burst", cur_idx, 1);
                if (cur_idx >= 1) begin
                    logic [15:0] exp_d;
                    exp_d = conv_val(4'(ch_arr[cur_idx-1])) >> (16 - exp_bits(len_arr[cur_idx]));
                    check(res_data == exp_d, "R5", "result data", res_data, exp_d);
                    check(int'(res_chan) == ch_arr[cur_idx-1], "R6", "result tag",
                          res_chan, ch_arr[cur_idx-1]);
                end
            end
            prev_valid = res_valid;
        end
    end

    task automatic do_req(input int ch, input int len, input int half);
        while (!ready) @(negedge clk);
        cur_idx++;
        ch_arr[cur_idx]  = ch;
        len_arr[cur_idx] = len;
        cur_half    = half;
        req_chan    = 4'(ch);
        req_len     = 2'(len);
        half_cycles = 8'(half);
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!ready, "R8", "busy after accept", ready, 0);
        check(!timeout_err, "R9", "flag cleared on accept", timeout_err, 0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!ready) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        start       = 1'b0;
        req_chan    = 4'h0;
        req_len     = 2'd0;
        half_cycles = 8'd2;
        timeout_lim = 16'd1000;
        adc_eoc     = 1'b1;
        adc_dout    = 1'b0;
        adc_result  = 16'hDEAD;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(adc_cs_n == 1'b1, "R1", "reset select", adc_cs_n, 1);
        check(adc_clk == 1'b0, "R1", "reset clock", adc_clk, 0);
        check(ready == 1'b1, "R1", "reset ready", ready, 1);
        check(res_valid == 1'b0, "R1", "reset strobe", res_valid, 0);
        check(timeout_err == 1'b0, "R1", "reset flag", timeout_err, 0);

        do_req(3, 0, 2);
        wait_idle();
        check(valid_seen == 0, "R7", "first burst strobes", valid_seen, 0);

        do_req(5, 1, 2);
        do_req(10, 2, 3);
        do_req(15, 3, 1);
        do_req(0, 0, 4);
        // R10: start while busy must be ignored.
        repeat (5) @(negedge clk);
        req_chan = 4'h7;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!ready, "R10", "busy start ignored", ready, 0);
        do_req(9, 1, 2);
        wait_idle();

        // R9: converter never finishes.
        hang        = 1'b1;
        timeout_lim = 16'(TO_LIM);
        do_req(6, 0, 2);
        wait (timeout_err === 1'b1);
        @(negedge clk);
        check(ready, "R9", "idle after timeout", ready, 1);
        check(err_seen == 1, "R9", "timeout seen", err_seen, 1);
        adc_eoc     = 1'b1;
        converting  = 1'b0;
        hang        = 1'b0;
        timeout_lim = 16'd1000;
        repeat (5) @(negedge clk);

        do_req(12, 2, 2);
        wait_idle();
        repeat (5) @(negedge clk);
        check(valid_seen == 7, "R6", "strobe count", valid_seen, 7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule